// File: doc/BRIEF.md
# Keyboard Scan Code Wake Detector

This block listens passively to the clock and data lines of a keyboard serial port and rebuilds every frame the keyboard sends toward the host. Each frame has a start bit of 0, eight data bits with the least significant bit first, an odd parity bit and a stop bit of 1. A high line level carries a logic 1. Data is sampled on each falling edge of the keyboard clock, after both lines have been synchronised to the system clock. A frame with a wrong start bit, wrong parity or wrong stop bit is dropped.

A received byte that equals the programmed wake scan code sets a sticky wake status bit. Software clears that bit by writing 1 to it. The wake request output is high while the status bit and its enable bit are both set. All state resets only on the standby power-on reset, so a programmed code and a pending wake survive a loss of main power. The recovered byte moves inside the block as a one-cycle valid strobe with no ready signal. A keyboard cannot be stalled, so there is no back-pressure: every byte is compared in the cycle it becomes valid. If the keyboard clock stops partway through a frame, a timeout puts the bit counter back to the start of a frame.

Top module: `kbd_wake_top`

## Requirements
- R1: After the standby reset, the scan code register (address 0), the status register (address 1) and the enable register (address 2) all read 0x00, and `wake_req_o` is low.
- R2: Address 0 stores and returns a full 8-bit scan code. Address 2 stores only bit 5, the wake enable, and every other bit of address 2 reads 0.
- R3: A valid frame whose data byte equals the scan code sets bit 5 of address 1. The frame has start 0, eight data bits LSB first, odd parity over data plus parity, and stop 1.
- R4: A valid frame whose byte differs from the scan code leaves the status bit clear.
- R5: A frame whose start bit is 1 is discarded. It produces no match even if its data byte equals the scan code.
- R6: A frame whose parity bit gives even parity is discarded.
- R7: A frame whose stop bit is 0 is discarded.
- R8: The status bit stays set until a write to address 1 with bit 5 at 1 clears it. A write with bit 5 at 0 has no effect.
- R9: `wake_req_o` is high exactly while the status bit and the enable bit are both 1.
- R10: If the keyboard clock has no falling edge for TIMEOUT_CYC system clocks in the middle of a frame, the bit counter returns to 0, and the next frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sb_por_n | input | 1 | Standby power-on reset, active low |
| kbd_clk_i | input | 1 | Keyboard clock line (snooped) |
| kbd_dat_i | input | 1 | Keyboard data line (snooped) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 code, 1 status, 2 enable |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| wake_req_o | output | 1 | Wake request, status AND enable |

## Verification
The assertions assume three things about the inputs. The keyboard lines move slowly compared with the system clock. A status clear write never lands in the same cycle as a match, since a simultaneous set takes priority. The bit counter, brought out of the receiver, never goes past the last bit of a frame. The bench drives each keyboard clock phase for many system clocks. It issues register writes only after a frame has finished and its latency has passed. It checks the timeout by leaving a partial frame idle for well beyond the limit.

// File: rtl/kbd_wake_pkg.sv
package kbd_wake_pkg;
  localparam int FRAME_BITS = 11;
  localparam int BCNT_W     = $clog2(FRAME_BITS);
  localparam int WAKE_BIT   = 5;

  typedef enum logic [1:0] {
    RA_CODE = 2'd0,
    RA_STS  = 2'd1,
    RA_EN   = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] st_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st_q[0] <= 1'b1;
          else        st_q[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st_q[i] <= 1'b1;
          else        st_q[i] <= st_q[i-1];
      end
    end
  endgenerate

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
  import kbd_wake_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kclk_s,
  input  logic              kdat_s,
  output logic              byte_vld_o,
  output logic [7:0]        byte_o,
  output logic [BCNT_W-1:0] bit_cnt_o
);
  localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(FRAME_BITS - 1);

  logic              kclk_d;
  logic              fall;
  logic [BCNT_W-1:0] bit_cnt_q;
  logic [FRAME_BITS-2:0] sh_q;
  logic [IDLE_W-1:0] idle_q;
  logic              frame_ok;

  assign fall = kclk_d & ~kclk_s;

  // sh_q[0]=start, sh_q[8:1]=data, sh_q[9]=parity; kdat_s is the stop bit
  assign frame_ok = (sh_q[0] == 1'b0) && (^sh_q[9:1] == 1'b1) && kdat_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kclk_d     <= 1'b1;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      idle_q     <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      kclk_d     <= kclk_s;
      byte_vld_o <= 1'b0;
      if (fall) begin
        idle_q <= '0;
        if (bit_cnt_q == LAST_BIT) begin
          bit_cnt_q <= '0;
          if (frame_ok) begin
            byte_vld_o <= 1'b1;
            byte_o     <= sh_q[8:1];
          end
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          sh_q      <= {kdat_s, sh_q[FRAME_BITS-2:1]};
        end
      end else if (bit_cnt_q == '0) begin
        idle_q <= '0;
      end else if (idle_q == IDLE_W'(TIMEOUT_CYC - 1)) begin
        idle_q    <= '0;
        bit_cnt_q <= '0;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  assign bit_cnt_o = bit_cnt_q;
endmodule

// File: rtl/kbd_wake_regs.sv
module kbd_wake_regs
  import kbd_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       match_i,
  output logic [7:0] code_o,
  output logic       sts_o,
  output logic       en_o,
  output logic       wake_o
);
  logic [7:0] code_q;
  logic       sts_q;
  logic       en_q;
  logic       clr;

  assign clr = wr_i && (addr_i == RA_STS) && wdata_i[WAKE_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      sts_q  <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (wr_i && addr_i == RA_CODE) code_q <= wdata_i;
      if (wr_i && addr_i == RA_EN)   en_q   <= wdata_i[WAKE_BIT];
      if (match_i)  sts_q <= 1'b1;
      else if (clr) sts_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CODE: rdata_o = code_q;
      RA_STS:  rdata_o[WAKE_BIT] = sts_q;
      RA_EN:   rdata_o[WAKE_BIT] = en_q;
      default: rdata_o = '0;
    endcase
  end

  assign code_o = code_q;
  assign sts_o  = sts_q;
  assign en_o   = en_q;
  assign wake_o = sts_q & en_q;
endmodule

// File: rtl/kbd_wake_top.sv
module kbd_wake_top
  import kbd_wake_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       sb_por_n,
  input  logic       kbd_clk_i,
  input  logic       kbd_dat_i,
  input  logic       reg_wr_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       wake_req_o
);
  logic              kclk_s, kdat_s;
  logic              frm_vld;
  logic [7:0]        frm_byte;
  logic [BCNT_W-1:0] bit_cnt;
  logic [7:0]        code;
  logic              sts, en;
  logic              match;

  kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(sb_por_n), .din(kbd_clk_i), .dout(kclk_s));
  kbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst_n(sb_por_n), .din(kbd_dat_i), .dout(kdat_s));

  kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk(clk), .rst_n(sb_por_n), .kclk_s(kclk_s), .kdat_s(kdat_s),
    .byte_vld_o(frm_vld), .byte_o(frm_byte), .bit_cnt_o(bit_cnt));

  assign match = frm_vld && (frm_byte == code);

  kbd_wake_regs u_regs (
    .clk(clk), .rst_n(sb_por_n), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .match_i(match),
    .code_o(code), .sts_o(sts), .en_o(en), .wake_o(wake_req_o));
endmodule

// File: rtl/kbd_wake_chk.sv
module kbd_wake_chk
  import kbd_wake_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [1:0]        reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic              wake_req_o,
  input logic              match,
  input logic              sts,
  input logic [BCNT_W-1:0] bit_cnt
);
  logic clr_wr;
  assign clr_wr = reg_wr_i && reg_addr_i == RA_STS && reg_wdata_i[WAKE_BIT];

  p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> sts);

  p_rise_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts) |-> $past(match));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr_wr) |=> sts);

  p_clear_drops_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !match) |=> !wake_req_o);

  p_en_reads_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == RA_EN) |-> ((reg_rdata_o & 8'hDF) == 8'h00));

  p_bitcnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= BCNT_W'(FRAME_BITS - 1));
endmodule

bind kbd_wake_top kbd_wake_chk u_chk (
  .clk(clk), .rst_n(sb_por_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .wake_req_o(wake_req_o),
  .match(match), .sts(sts), .bit_cnt(bit_cnt));

// File: tb/sim_kbd_wake_top.sv
`timescale 1ns/1ps
module sim_kbd_wake_top;
  localparam int TMO  = 1000;
  localparam int HALF = 10;

  logic       clk = 1'b0;
  logic       sb_por_n = 1'b0;
  logic       kclk = 1'b1, kdat = 1'b1;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       wake;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  kbd_wake_top #(.TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .sb_por_n(sb_por_n), .kbd_clk_i(kclk), .kbd_dat_i(kdat),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .wake_req_o(wake));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  // nbits < 11 sends a partial frame
  task automatic send(input logic [7:0] d, input logic st, input logic pflip,
                      input logic sp, input int nbits);
    logic [10:0] f;
    f = {sp, (~^d) ^ pflip, d, st};
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); kdat = f[i];
      repeat (HALF) @(negedge clk);
      kclk = 1'b0;
      repeat (HALF) @(negedge clk);
      kclk = 1'b1;
    end
    @(negedge clk); kdat = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset;
    rreg("R1 code", 2'd0, 8'h00);
    rreg("R1 sts", 2'd1, 8'h00);
    rreg("R1 en", 2'd2, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_regs;
    wreg(2'd0, 8'h1C); rreg("R2 code", 2'd0, 8'h1C);
    wreg(2'd2, 8'hFF); rreg("R2 en", 2'd2, 8'h20);
    wreg(2'd2, 8'hDF); rreg("R2 en off", 2'd2, 8'h00);
  endtask

  task automatic t_match;
    send(8'h1C, 1'b0, 1'b0, 1'b1, 11);
    rreg("R3 match", 2'd1, 8'h20);
    chk("R9 no en", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_w1c;
    wreg(2'd1, 8'hDF); rreg("R8 w0 keeps", 2'd1, 8'h20);
    send(8'h55, 1'b0, 1'b0, 1'b1, 11);
    rreg("R8 sticky", 2'd1, 8'h20);
    wreg(2'd1, 8'h20); rreg("R8 w1 clears", 2'd1, 8'h00);
  endtask

  task automatic t_nomatch;
    send(8'h1D, 1'b0, 1'b0, 1'b1, 11);
    rreg("R4 other byte", 2'd1, 8'h00);
  endtask

  task automatic t_bad;
    send(8'h1C, 1'b1, 1'b0, 1'b1, 11); rreg("R5 bad start", 2'd1, 8'h00);
    send(8'h1C, 1'b0, 1'b1, 1'b1, 11); rreg("R6 bad parity", 2'd1, 8'h00);
    send(8'h1C, 1'b0, 1'b0, 1'b0, 11); rreg("R7 bad stop", 2'd1, 8'h00);
    send(8'h1C, 1'b0, 1'b0, 1'b1, 11); rreg("R5 realign", 2'd1, 8'h20);
    wreg(2'd1, 8'h20);
  endtask

  task automatic t_wake;
    wreg(2'd2, 8'h20);
    chk("R9 en only", {7'd0, wake}, 8'h00);
    send(8'h1C, 1'b0, 1'b0, 1'b1, 11);
    chk("R9 both", {7'd0, wake}, 8'h01);
    wreg(2'd2, 8'h00);
    chk("R9 en off", {7'd0, wake}, 8'h00);
    wreg(2'd2, 8'h20);
    chk("R9 en on", {7'd0, wake}, 8'h01);
    wreg(2'd1, 8'h20);
    chk("R9 sts clr", {7'd0, wake}, 8'h00);
  endtask

  task automatic t_timeout;
    wreg(2'd0, 8'hA5);
    send(8'hFF, 1'b0, 1'b0, 1'b1, 4);
    repeat (TMO + 200) @(negedge clk);
    send(8'hA5, 1'b0, 1'b0, 1'b1, 11);
    rreg("R10 timeout", 2'd1, 8'h20);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    sb_por_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_regs;
    t_match;
    t_w1c;
    t_nomatch;
    t_bad;
    t_wake;
    t_timeout;
    summary;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    summary;
  end
endmodule